// File: doc/BRIEF.md
# Prescaled Trigger Decision Unit

This block forms the final trigger decision for one event. A strobed vector of input trigger bits is judged against a set of output logics. Each logic is an OR of product terms, and each term is an AND over selected input bits, any of which may be taken inverted. Software loads the terms and the per-output prescale factors through a small write port. After the logics are evaluated, each output passes through its own prescaler. Two result vectors come out: the raw fired bits and the prescaled fired bits.

The input vector, the raw result and the prescaled result are each packed into 32-bit summary words, and all three are registered together with a one-cycle valid pulse. The prescaler is deterministic. It counts only the events on which its own output fired, and it lets through the event on which the count wraps. A factor of 0 blocks the output and a factor of 1 passes every event. Only the first `N_LOGIC` outputs carry a logic. Outputs above that limit are held inactive.

Top module: `gdl_decision`

## Requirements
- R1: A product term is true when every input bit selected by its mask equals the value wanted: the bit itself where the matching inversion bit is 0, its complement where it is 1. An output fires when any of its used terms is true.
- R2: An output that has no used term fires on every strobed event.
- R3: A term whose mask is all zero is unused. It neither fires nor blocks an output that has other used terms.
- R4: An output whose prescale factor is 0 never sets its prescaled bit.
- R5: An output whose prescale factor is 1 has its prescaled bit equal to its raw bit on every event.
- R6: For a factor f above 1, the prescaled bit is set on the f-th, 2f-th, ... fired event of that output. Events on which the output did not fire do not advance the count.
- R7: A prescaled bit is never set unless the raw bit of the same output is set on the same event.
- R8: Output i appears in the raw and prescaled words at flat bit i, which is word i/32, position i%32. Input bit j appears in the input summary at flat bit j. Bits above the configured count read 0.
- R9: Outputs with index N_LOGIC or above keep raw and prescaled bits at 0, whatever they are programmed with.
- R10: Results appear one clock after a strobe, together with a single-cycle `out_valid_o` pulse. Without a strobe the summary words hold their values.
- R11: After synchronous reset all summary words and `out_valid_o` are 0, all terms are unused, and all factors and prescale counts are 0.
- R12: Writing a prescale factor restarts that output's count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Event strobe |
| in_bits_i | input | N_IN | Input trigger bits |
| cfg_term_we_i | input | 1 | Write one term entry |
| cfg_out_idx_i | input | clog2(N_OUT) | Output selected by a term or factor write |
| cfg_term_idx_i | input | clog2(N_TERM) | Term selected by a term write |
| cfg_mask_i | input | N_IN | Literal mask: bit set means the input takes part |
| cfg_inv_i | input | N_IN | Inversion mask: bit set means the input is wanted at 0 |
| cfg_ps_we_i | input | 1 | Write the prescale factor of the selected output |
| cfg_ps_val_i | input | PS_W | Prescale factor |
| in_sum_o | output | 32*ceil(N_IN/32) | Packed input summary words |
| raw_sum_o | output | 32*ceil(N_OUT/32) | Packed raw fired words |
| ps_sum_o | output | 32*ceil(N_OUT/32) | Packed prescaled fired words |
| out_valid_o | output | 1 | One-cycle pulse marking new summary words |

## Verification
The assertions assume that `in_valid_i` is low while reset is held, since the valid-follows-strobe property compares against the strobe of the previous cycle. The factor-based properties assume that no factor is written in the same cycle as a strobe, because the count is restarted at that edge. The bench drives every configuration write on its own, separated from the strobes by at least one idle cycle. It also holds the strobe low during reset, so the stimulus stays inside both assumptions.

// File: rtl/gdl_pkg.sv
package gdl_pkg;
    localparam int WORD_W = 32;

    function automatic int words_for(input int bits);
        return (bits + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction
endpackage

// File: rtl/gdl_term_table.sv
module gdl_term_table
    import gdl_pkg::*;
#(
    parameter int N_IN   = 48,
    parameter int N_OUT  = 36,
    parameter int N_TERM = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we_i,
    input  logic [idx_width(N_OUT)-1:0]        out_idx_i,
    input  logic [idx_width(N_TERM)-1:0]       term_idx_i,
    input  logic [N_IN-1:0]                    mask_i,
    input  logic [N_IN-1:0]                    inv_i,
    output logic [N_OUT*N_TERM*N_IN-1:0]       mask_o,
    output logic [N_OUT*N_TERM*N_IN-1:0]       inv_o
);
    localparam int ENTRIES = N_OUT * N_TERM;
    localparam int OW      = idx_width(N_OUT);
    localparam int TW      = idx_width(N_TERM);

    typedef struct packed {
        logic [ENTRIES-1:0][N_IN-1:0] mask;
        logic [ENTRIES-1:0][N_IN-1:0] inv;
    } table_t;

    table_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (we_i && out_idx_i == OW'(e / N_TERM) && term_idx_i == TW'(e % N_TERM)) begin
                s_d.mask[e] = mask_i;
                s_d.inv[e]  = inv_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign mask_o = s_q.mask;
    assign inv_o  = s_q.inv;
endmodule

// File: rtl/gdl_logic_eval.sv
module gdl_logic_eval #(
    parameter int N_IN    = 48,
    parameter int N_OUT   = 36,
    parameter int N_TERM  = 2,
    parameter int N_LOGIC = 34
) (
    input  logic [N_IN-1:0]              bits_i,
    input  logic [N_OUT*N_TERM*N_IN-1:0] mask_i,
    input  logic [N_OUT*N_TERM*N_IN-1:0] inv_i,
    output logic [N_OUT-1:0]             fired_o
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        if (o < N_LOGIC) begin : g_live
            logic [N_TERM-1:0] hit;
            logic [N_TERM-1:0] used;
            for (genvar t = 0; t < N_TERM; t++) begin : g_term
                localparam int BASE = (o * N_TERM + t) * N_IN;
                assign used[t] = |mask_i[BASE +: N_IN];
                assign hit[t]  = &((bits_i ^ inv_i[BASE +: N_IN]) | ~mask_i[BASE +: N_IN]);
            end
            assign fired_o[o] = (used == '0) ? 1'b1 : |(hit & used);
        end else begin : g_dead
            assign fired_o[o] = 1'b0;
        end
    end
endmodule

// File: rtl/gdl_prescaler.sv
module gdl_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic [PS_W-1:0] val_i,
    input  logic            event_i,
    output logic [PS_W-1:0] fac_o,
    output logic            pass_o
);
    typedef struct packed {
        logic [PS_W-1:0] fac;
        logic [PS_W-1:0] cnt;
    } ps_t;

    ps_t  s_d, s_q;
    logic wrap;
    logic multi;

    always_comb begin
        multi  = s_q.fac > PS_W'(1);
        wrap   = s_q.cnt >= (s_q.fac - PS_W'(1));
        pass_o = (s_q.fac == PS_W'(1)) | (multi & wrap);
        s_d    = s_q;
        if (wr_i) begin
            s_d.fac = val_i;
            s_d.cnt = '0;
        end else if (event_i && multi) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + PS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign fac_o = s_q.fac;
endmodule

// File: rtl/gdl_decision.sv
module gdl_decision
    import gdl_pkg::*;
#(
    parameter int N_IN    = 48,
    parameter int N_OUT   = 36,
    parameter int N_TERM  = 2,
    parameter int N_LOGIC = 34,
    parameter int PS_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid_i,
    input  logic [N_IN-1:0]                     in_bits_i,
    input  logic                                cfg_term_we_i,
    input  logic [idx_width(N_OUT)-1:0]         cfg_out_idx_i,
    input  logic [idx_width(N_TERM)-1:0]        cfg_term_idx_i,
    input  logic [N_IN-1:0]                     cfg_mask_i,
    input  logic [N_IN-1:0]                     cfg_inv_i,
    input  logic                                cfg_ps_we_i,
    input  logic [PS_W-1:0]                     cfg_ps_val_i,
    output logic [WORD_W*words_for(N_IN)-1:0]   in_sum_o,
    output logic [WORD_W*words_for(N_OUT)-1:0]  raw_sum_o,
    output logic [WORD_W*words_for(N_OUT)-1:0]  ps_sum_o,
    output logic                                out_valid_o
);
    localparam int IN_W  = WORD_W * words_for(N_IN);
    localparam int OUT_W = WORD_W * words_for(N_OUT);
    localparam int OW    = idx_width(N_OUT);

    logic [N_OUT*N_TERM*N_IN-1:0] tbl_mask;
    logic [N_OUT*N_TERM*N_IN-1:0] tbl_inv;
    logic [N_OUT-1:0]             fired;
    logic [N_OUT-1:0]             pass;
    logic [N_OUT*PS_W-1:0]        ps_fac_flat;

    gdl_term_table #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) i_table (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_term_we_i),
        .out_idx_i (cfg_out_idx_i),
        .term_idx_i(cfg_term_idx_i),
        .mask_i    (cfg_mask_i),
        .inv_i     (cfg_inv_i),
        .mask_o    (tbl_mask),
        .inv_o     (tbl_inv)
    );

    gdl_logic_eval #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .N_LOGIC(N_LOGIC)) i_eval (
        .bits_i (in_bits_i),
        .mask_i (tbl_mask),
        .inv_i  (tbl_inv),
        .fired_o(fired)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_ps
        gdl_prescaler #(.PS_W(PS_W)) i_ps (
            .clk    (clk),
            .rst    (rst),
            .wr_i   (cfg_ps_we_i && cfg_out_idx_i == OW'(o)),
            .val_i  (cfg_ps_val_i),
            .event_i(in_valid_i && fired[o]),
            .fac_o  (ps_fac_flat[o*PS_W +: PS_W]),
            .pass_o (pass[o])
        );
    end

    typedef struct packed {
        logic             valid;
        logic [IN_W-1:0]  ins;
        logic [OUT_W-1:0] raw;
        logic [OUT_W-1:0] ps;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = in_valid_i;
        if (in_valid_i) begin
            s_d.ins = IN_W'(in_bits_i);
            s_d.raw = OUT_W'(fired);
            s_d.ps  = OUT_W'(fired & pass);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign in_sum_o    = s_q.ins;
    assign raw_sum_o   = s_q.raw;
    assign ps_sum_o    = s_q.ps;
    assign out_valid_o = s_q.valid;
endmodule

// File: rtl/gdl_decision_chk.sv
module gdl_decision_chk
    import gdl_pkg::*;
#(
    parameter int N_IN    = 48,
    parameter int N_OUT   = 36,
    parameter int N_LOGIC = 34,
    parameter int PS_W    = 8
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               in_valid_i,
    input logic [WORD_W*words_for(N_IN)-1:0]  in_sum_o,
    input logic [WORD_W*words_for(N_OUT)-1:0] raw_sum_o,
    input logic [WORD_W*words_for(N_OUT)-1:0] ps_sum_o,
    input logic                               out_valid_o,
    input logic [N_OUT*PS_W-1:0]              ps_fac_flat
);
    localparam int IN_W  = WORD_W * words_for(N_IN);
    localparam int OUT_W = WORD_W * words_for(N_OUT);

    // R7
    ps_within_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (ps_sum_o & ~raw_sum_o) == '0);

    // R10
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o == $past(in_valid_i));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid_i) |-> ($stable(raw_sum_o) && $stable(ps_sum_o) && $stable(in_sum_o)));

    // R9
    inactive_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_sum_o >> N_LOGIC) == '0 && (ps_sum_o >> N_LOGIC) == '0);

    // R8
    if (IN_W > N_IN) begin : g_in_pad
        pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
            in_sum_o[IN_W-1:N_IN] == '0);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_fac
        // R4
        block_zero_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid_o |-> ($past(ps_fac_flat[o*PS_W +: PS_W]) != '0 || !ps_sum_o[o]));
        // R5
        pass_all_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid_o |-> ($past(ps_fac_flat[o*PS_W +: PS_W]) != PS_W'(1) || ps_sum_o[o] == raw_sum_o[o]));
    end
endmodule

bind gdl_decision gdl_decision_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_LOGIC(N_LOGIC), .PS_W(PS_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid_i),
    .in_sum_o   (in_sum_o),
    .raw_sum_o  (raw_sum_o),
    .ps_sum_o   (ps_sum_o),
    .out_valid_o(out_valid_o),
    .ps_fac_flat(ps_fac_flat)
);

// File: tb/test_gdl_decision.sv
`timescale 1ns/1ps
module test_gdl_decision;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [47:0] in_bits = '0;
    logic        term_we = 1'b0;
    logic [5:0]  out_idx = '0;
    logic [0:0]  term_idx = '0;
    logic [47:0] mask = '0;
    logic [47:0] inv = '0;
    logic        ps_we = 1'b0;
    logic [7:0]  ps_val = '0;
    logic [63:0] in_sum, raw_sum, ps_sum;
    logic        out_valid;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    gdl_decision i_gdl_decision (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_bits_i(in_bits),
        .cfg_term_we_i(term_we), .cfg_out_idx_i(out_idx), .cfg_term_idx_i(term_idx),
        .cfg_mask_i(mask), .cfg_inv_i(inv), .cfg_ps_we_i(ps_we), .cfg_ps_val_i(ps_val),
        .in_sum_o(in_sum), .raw_sum_o(raw_sum), .ps_sum_o(ps_sum), .out_valid_o(out_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_term(input int o, input int t, input logic [47:0] m, input logic [47:0] v);
        @(negedge clk);
        term_we = 1'b1; out_idx = 6'(o); term_idx = 1'(t); mask = m; inv = v;
        @(negedge clk);
        term_we = 1'b0;
    endtask

    task automatic wr_ps(input int o, input int f);
        @(negedge clk);
        ps_we = 1'b1; out_idx = 6'(o); ps_val = 8'(f);
        @(negedge clk);
        ps_we = 1'b0;
    endtask

    // strobe one event; on return the registered result is visible
    task automatic strobe(input logic [47:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_bits = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 in_sum", in_sum, 64'h0);
        check("R11 raw", raw_sum, 64'h0);
        check("R11 ps", ps_sum, 64'h0);
        check("R11 valid", {63'h0, out_valid}, 64'h1 & 64'h0);
        strobe(48'h0);
        check("R2 R11 all unprogrammed logics fire", raw_sum, 64'h3_FFFF_FFFF);
        check("R4 R11 factors reset to 0", ps_sum, 64'h0);
        check("R10 valid pulse", {63'h0, out_valid}, 64'h1);
        @(negedge clk);
        check("R10 valid single cycle", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_sop;
        // out0 = (b1 & !b2) | b40
        wr_term(0, 0, 48'h6, 48'h4);
        wr_term(0, 1, 48'h0100_0000_0000, 48'h0);
        strobe(48'h2);
        check("R1 term with inverted literal true", {63'h0, raw_sum[0]}, 64'h1);
        strobe(48'h6);
        check("R1 inverted literal blocks", {63'h0, raw_sum[0]}, 64'h0);
        strobe(48'h0100_0000_0000);
        check("R1 second term fires", {63'h0, raw_sum[0]}, 64'h1);
        strobe(48'h0);
        check("R1 no term true", {63'h0, raw_sum[0]}, 64'h0);
    endtask

    task automatic t_unused_term;
        // out1: term0 unused, term1 = b5
        wr_term(1, 1, 48'h20, 48'h0);
        strobe(48'h0);
        check("R3 zero-mask term ignored", {63'h0, raw_sum[1]}, 64'h0);
        strobe(48'h20);
        check("R3 used term fires", {63'h0, raw_sum[1]}, 64'h1);
        check("R4 factor 0 blocks", {63'h0, ps_sum[1]}, 64'h0);
    endtask

    task automatic t_pass_all;
        wr_ps(0, 1);
        for (int k = 0; k < 3; k++) begin
            strobe(48'h2);
            check("R5 factor 1 passes", {63'h0, ps_sum[0]}, 64'h1);
        end
        strobe(48'h0);
        check("R7 no prescaled bit without raw", {63'h0, ps_sum[0]}, 64'h0);
    endtask

    task automatic t_divide;
        logic [47:0] pat [8] = '{48'h20, 48'h0, 48'h20, 48'h20, 48'h0, 48'h20, 48'h20, 48'h20};
        logic        exp [8] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
        wr_ps(1, 3);
        for (int k = 0; k < 8; k++) begin
            strobe(pat[k]);
            check("R6 every third fired event", {63'h0, ps_sum[1]}, {63'h0, exp[k]});
        end
    endtask

    task automatic t_restart;
        strobe(48'h20);
        strobe(48'h20);
        wr_ps(1, 3);
        strobe(48'h20);
        check("R12 count restarted (1st)", {63'h0, ps_sum[1]}, 64'h0);
        strobe(48'h20);
        check("R12 count restarted (2nd)", {63'h0, ps_sum[1]}, 64'h0);
        strobe(48'h20);
        check("R12 count restarted (3rd)", {63'h0, ps_sum[1]}, 64'h1);
    endtask

    task automatic t_packing;
        wr_term(33, 0, 48'h8000_0000_0000, 48'h0);
        strobe(48'h0);
        check("R8 out33 quiet", {63'h0, raw_sum[33]}, 64'h0);
        strobe(48'h8000_0000_0000);
        check("R8 out33 in word1 bit1", raw_sum[63:32] & 64'h2, 64'h2);
        check("R8 input bit47 in word1 bit15", in_sum, 64'h0000_8000_0000_0000);
        strobe(48'hFFFF_FFFF_FFFF);
        check("R8 input padding zero", in_sum, 64'h0000_FFFF_FFFF_FFFF);
    endtask

    task automatic t_inactive;
        wr_term(35, 0, 48'h1, 48'h0);
        wr_ps(35, 1);
        strobe(48'h1);
        check("R9 output beyond logic count", raw_sum[63:34], 64'h0);
        check("R9 prescaled beyond logic count", ps_sum[63:34], 64'h0);
    endtask

    task automatic t_hold;
        logic [63:0] r, p, s;
        strobe(48'h2);
        r = raw_sum; p = ps_sum; s = in_sum;
        @(negedge clk);
        in_bits = 48'h0100_0000_0020;
        repeat (3) @(negedge clk);
        check("R10 raw holds", raw_sum, r);
        check("R10 ps holds", ps_sum, p);
        check("R10 input summary holds", in_sum, s);
        check("R10 no valid without strobe", {63'h0, out_valid}, 64'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sop();
        t_unused_term();
        t_pass_all();
        t_divide();
        t_restart();
        t_packing();
        t_inactive();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule